// File: doc/BRIEF.md
# SPI FIFO Status and Watermark Interrupt Unit

This block sits between the register interface of an SPI controller and its serial shifter. It holds two byte-wide queues of 256 entries: a transmit queue filled by software and drained by the shifter, and a receive queue filled by the shifter and drained by software. It does no serial shifting and makes no serial clock.

From the queue levels it derives a five-bit status word and a four-bit raw interrupt word. Two of the raw bits compare the queue levels with programmable 7-bit thresholds. One flags a receive overrun, and one flags a receive queue that has gone unread for a set number of serial bit times. A mask register selects which raw bits reach the masked word and the single interrupt line. A clear strobe resets the two sticky flags.

Top module: `sfq_irq_status`

## Requirements
- R1: Each queue returns bytes in the order they were accepted. The read data port of a non-empty queue always shows its oldest byte, and a pop removes that byte.
- R2: Status bit 0 is 1 when the transmit queue is empty, and bit 1 is 1 when it is not full. Bit 2 is 1 when the receive queue holds at least one byte, and bit 3 is 1 when it holds 256 bytes.
- R3: A push into a full transmit queue is dropped. A pop from an empty queue changes no state, and an empty queue's read data is 0.
- R4: A push into a full receive queue drops the byte and sets raw bit 0 (overrun). The bit stays set until a clear write with data bit 0 set. If a new overrun happens in the same cycle as the clear, the bit stays set.
- R5: Raw bit 1 (timeout) sets on the 32nd bit tick counted while the receive queue is non-empty and not popped. An empty queue, a receive pop or a clear write with data bit 1 set restarts the count. The bit stays set until a clear write with data bit 1 set, and that clear also wins over a same-cycle timeout.
- R6: The threshold word carries the receive threshold in bits 14:8 and the transmit threshold in bits 6:0. Both reset to 32. Raw bit 2 is 1 when the receive level is at or above its threshold, and raw bit 3 is 1 when the transmit level is at or below its threshold.
- R7: The masked word is the raw word ANDed with the 4-bit mask register, which resets to 0. The interrupt output is the OR of the masked bits.
- R8: After reset both queues are empty, status reads 0b00011, raw reads 0b1000 and the interrupt output is 0.
- R9: Status bit 4 (busy) is 1 when the shifter reports busy or the transmit queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Software writes a transmit byte |
| tx_wdata | input | 8 | Transmit byte |
| tx_pop | input | 1 | Shifter takes the oldest transmit byte |
| tx_rdata | output | 8 | Oldest transmit byte, 0 when empty |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Software takes the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte, 0 when empty |
| shifter_busy | input | 1 | Shifter is mid-frame |
| bit_tick | input | 1 | One pulse per serial bit time |
| wm_we | input | 1 | Threshold word write strobe |
| wm_wdata | input | 16 | Threshold word |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 4 | Mask value |
| clr_we | input | 1 | Clear write strobe |
| clr_wdata | input | 2 | Clear bits: 0 overrun, 1 timeout |
| status | output | 5 | Status word |
| raw_irq | output | 4 | Raw interrupt word |
| masked_irq | output | 4 | Raw word ANDed with mask |
| irq | output | 1 | OR of masked bits |

## Verification
The hardest states to reach are the full receive queue, where overrun arises, and the idle window where the timeout fires. Both need long runs with no receive pops, and random traffic with balanced push and pop rates almost never produces them. The stimulus therefore runs biased phases: one pushes on nearly every cycle with pops switched off until the queue overflows, and then clears the overrun in the same cycle as another overflowing push. Another phase leaves bytes in the receive queue and feeds exactly 31 and then 32 bit ticks. Random phases with re-programmed thresholds and masks run around these so that all four raw bits toggle.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  localparam int WM_W      = 7;
  localparam int WM_WORD_W = 16;
  localparam int WM_RX_LSB = 8;
  localparam int WM_TX_LSB = 0;
  localparam int RAW_W     = 4;
  localparam int STAT_W    = 5;
  localparam int CLR_W     = 2;
  localparam int IRQ_OVR   = 0;
  localparam int IRQ_TMO   = 1;
  localparam int IRQ_RXW   = 2;
  localparam int IRQ_TXW   = 3;

  typedef struct packed {
    logic busy;
    logic rx_full;
    logic rx_nempty;
    logic tx_nfull;
    logic tx_empty;
  } stat_t;
endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [DW-1:0]            wdata,
  input  logic                     pop,
  output logic [DW-1:0]            rdata,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wr_d  = do_push ? bump(wr_q) : wr_q;
    rd_d  = do_pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  assign rdata = empty ? '0 : mem[rd_q];
  assign level = cnt_q;
endmodule

// File: rtl/sfq_rx_idle.sv
module sfq_rx_idle #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_empty,
  input  logic rx_pop,
  input  logic restart,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hold, at_end;

  assign hold   = restart | rx_pop | rx_empty;
  assign at_end = (cnt_q == CW'(LIMIT - 1));
  assign expire = tick & ~hold & at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (hold)                 cnt_d = '0;
    else if (tick && !at_end) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sfq_irq_status.sv
module sfq_irq_status #(
  parameter int DW       = 8,
  parameter int DEPTH    = 256,
  parameter int TMO_BITS = 32,
  parameter int WM_RST   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tx_push,
  input  logic [DW-1:0]              tx_wdata,
  input  logic                       tx_pop,
  output logic [DW-1:0]              tx_rdata,
  input  logic                       rx_push,
  input  logic [DW-1:0]              rx_wdata,
  input  logic                       rx_pop,
  output logic [DW-1:0]              rx_rdata,
  input  logic                       shifter_busy,
  input  logic                       bit_tick,
  input  logic                       wm_we,
  input  logic [sfq_pkg::WM_WORD_W-1:0] wm_wdata,
  input  logic                       mask_we,
  input  logic [sfq_pkg::RAW_W-1:0]  mask_wdata,
  input  logic                       clr_we,
  input  logic [sfq_pkg::CLR_W-1:0]  clr_wdata,
  output logic [sfq_pkg::STAT_W-1:0] status,
  output logic [sfq_pkg::RAW_W-1:0]  raw_irq,
  output logic [sfq_pkg::RAW_W-1:0]  masked_irq,
  output logic                       irq
);
  import sfq_pkg::*;
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0]    tx_lvl, rx_lvl;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [WM_W-1:0]  rx_thr_q, rx_thr_d, tx_thr_q, tx_thr_d;
  logic [RAW_W-1:0] mask_q, mask_d;
  logic             ovr_q, ovr_d, tmo_q, tmo_d;
  logic             ovr_set, tmo_set, clr_ovr, clr_tmo;
  stat_t            st;

  sfq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata),
    .pop(tx_pop), .rdata(tx_rdata), .level(tx_lvl),
    .full(tx_full), .empty(tx_empty));

  sfq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
    .pop(rx_pop), .rdata(rx_rdata), .level(rx_lvl),
    .full(rx_full), .empty(rx_empty));

  assign clr_ovr = clr_we & clr_wdata[IRQ_OVR];
  assign clr_tmo = clr_we & clr_wdata[IRQ_TMO];
  assign ovr_set = rx_push & rx_full;

  sfq_rx_idle #(.LIMIT(TMO_BITS)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .rx_empty(rx_empty),
    .rx_pop(rx_pop), .restart(clr_tmo), .expire(tmo_set));

  always_comb begin
    rx_thr_d = rx_thr_q;
    tx_thr_d = tx_thr_q;
    mask_d   = mask_q;
    if (wm_we) begin
      rx_thr_d = wm_wdata[WM_RX_LSB +: WM_W];
      tx_thr_d = wm_wdata[WM_TX_LSB +: WM_W];
    end
    if (mask_we) mask_d = mask_wdata;
    ovr_d = ovr_set ? 1'b1 : (clr_ovr ? 1'b0 : ovr_q);
    tmo_d = clr_tmo ? 1'b0 : (tmo_set ? 1'b1 : tmo_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_thr_q <= WM_W'(WM_RST);
      tx_thr_q <= WM_W'(WM_RST);
      mask_q   <= '0;
      ovr_q    <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      rx_thr_q <= rx_thr_d;
      tx_thr_q <= tx_thr_d;
      mask_q   <= mask_d;
      ovr_q    <= ovr_d;
      tmo_q    <= tmo_d;
    end
  end

  always_comb begin
    st.tx_empty  = tx_empty;
    st.tx_nfull  = ~tx_full;
    st.rx_nempty = ~rx_empty;
    st.rx_full   = rx_full;
    st.busy      = shifter_busy | ~tx_empty;
    raw_irq          = '0;
    raw_irq[IRQ_OVR] = ovr_q;
    raw_irq[IRQ_TMO] = tmo_q;
    raw_irq[IRQ_RXW] = (rx_lvl >= CW'(rx_thr_q));
    raw_irq[IRQ_TXW] = (tx_lvl <= CW'(tx_thr_q));
  end

  assign status     = st;
  assign masked_irq = raw_irq & mask_q;
  assign irq        = |masked_irq;
endmodule

// File: rtl/sfq_irq_status_chk.sv
module sfq_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_push,
  input logic       rx_pop,
  input logic [7:0] rx_rdata,
  input logic       clr_we,
  input logic [1:0] clr_wdata,
  input logic [4:0] status,
  input logic [3:0] raw_irq,
  input logic       irq
);
  AST_RX_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |-> status[2]); // R2
  AST_TX_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> status[1]); // R2
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !status[2] |-> (rx_rdata == 8'h00)); // R3
  AST_EMPTY_POP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[2] && rx_pop && !rx_push) |=> !status[2]); // R3
  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && status[3]) |=> raw_irq[0]); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_irq[0] && !(clr_we && clr_wdata[0])) |=> raw_irq[0]); // R4
  AST_TMO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_wdata[1]) |=> !raw_irq[1]); // R5
  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_irq != 4'h0)); // R7
endmodule

bind sfq_irq_status sfq_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop),
  .rx_rdata(rx_rdata), .clr_we(clr_we), .clr_wdata(clr_wdata),
  .status(status), .raw_irq(raw_irq), .irq(irq));

// File: tb/sim_sfq_irq_status.sv
module sim_sfq_irq_status;
  localparam int DEPTH = 256;
  localparam int TMO   = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_push, tx_pop, rx_push, rx_pop, shifter_busy, bit_tick;
  logic [7:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata;
  logic wm_we, mask_we, clr_we;
  logic [15:0] wm_wdata;
  logic [3:0] mask_wdata, raw_irq, masked_irq;
  logic [1:0] clr_wdata;
  logic [4:0] status;
  logic irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int m_tcnt = 0;
  bit m_ovr = 0, m_tmo = 0;
  int m_rthr = 32, m_tthr = 32;
  logic [3:0] m_mask = 4'h0;

  always #4 clk = ~clk;

  sfq_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_wdata(tx_wdata),
    .tx_pop(tx_pop), .tx_rdata(tx_rdata), .rx_push(rx_push),
    .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .shifter_busy(shifter_busy), .bit_tick(bit_tick), .wm_we(wm_we),
    .wm_wdata(wm_wdata), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata), .status(status),
    .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] exp_status();
    return {shifter_busy | (txq.size() != 0), rxq.size() == DEPTH,
            rxq.size() != 0, txq.size() != DEPTH, txq.size() == 0};
  endfunction

  function automatic logic [3:0] exp_raw();
    return {txq.size() <= m_tthr, rxq.size() >= m_rthr, m_tmo, m_ovr};
  endfunction

  task automatic compare_all();
    logic [4:0] es;
    logic [3:0] er;
    logic [7:0] eh;
    es = exp_status();
    er = exp_raw();
    check(status[3:0] == es[3:0], "R2 status", status, es);
    check(status[4] == es[4], "R9 busy", status[4], es[4]);
    check(raw_irq[0] == er[0], "R4 overrun", raw_irq[0], er[0]);
    check(raw_irq[1] == er[1], "R5 timeout", raw_irq[1], er[1]);
    check(raw_irq[3:2] == er[3:2], "R6 watermark", raw_irq[3:2], er[3:2]);
    check(masked_irq == (er & m_mask), "R7 masked", masked_irq, er & m_mask);
    check(irq == |(er & m_mask), "R7 irq", irq, |(er & m_mask));
    eh = (txq.size() != 0) ? txq[0] : 8'h00;
    check(tx_rdata == eh, (txq.size() != 0) ? "R1 tx head" : "R3 tx empty", tx_rdata, eh);
    eh = (rxq.size() != 0) ? rxq[0] : 8'h00;
    check(rx_rdata == eh, (rxq.size() != 0) ? "R1 rx head" : "R3 rx empty", rx_rdata, eh);
  endtask

  task automatic idle_inputs();
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; bit_tick = 0;
    wm_we = 0; mask_we = 0; clr_we = 0; shifter_busy = 0;
    tx_wdata = 0; rx_wdata = 0; wm_wdata = 0; mask_wdata = 0; clr_wdata = 0;
  endtask

  // advance one clock: inputs were set at the falling edge
  task automatic step();
    bit t_pop, t_push, r_pop, r_push, r_empty, c_ovr, c_tmo, ovr_set, tmo_set;
    @(posedge clk);
    t_pop   = tx_pop && txq.size() > 0;
    t_push  = tx_push && txq.size() < DEPTH;
    r_pop   = rx_pop && rxq.size() > 0;
    r_push  = rx_push && rxq.size() < DEPTH;
    r_empty = rxq.size() == 0;
    ovr_set = rx_push && rxq.size() == DEPTH;
    c_ovr   = clr_we && clr_wdata[0];
    c_tmo   = clr_we && clr_wdata[1];
    tmo_set = bit_tick && !c_tmo && !rx_pop && !r_empty && m_tcnt == TMO - 1;
    if (c_tmo || rx_pop || r_empty) m_tcnt = 0;
    else if (bit_tick && m_tcnt != TMO - 1) m_tcnt++;
    m_tmo = c_tmo ? 1'b0 : (tmo_set ? 1'b1 : m_tmo);
    m_ovr = ovr_set ? 1'b1 : (c_ovr ? 1'b0 : m_ovr);
    if (wm_we) begin
      m_rthr = int'(wm_wdata[14:8]);
      m_tthr = int'(wm_wdata[6:0]);
    end
    if (mask_we) m_mask = mask_wdata;
    if (t_pop) void'(txq.pop_front());
    if (r_pop) void'(rxq.pop_front());
    if (t_push) txq.push_back(tx_wdata);
    if (r_push) rxq.push_back(rx_wdata);
    #1;
    compare_all();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic rand_cycle(input int p_tpush, input int p_tpop, input int p_rpush,
                            input int p_rpop, input int p_tick, input int p_ctl);
    tx_push = ($urandom_range(99) < p_tpush);
    tx_pop  = ($urandom_range(99) < p_tpop);
    rx_push = ($urandom_range(99) < p_rpush);
    rx_pop  = ($urandom_range(99) < p_rpop);
    bit_tick = ($urandom_range(99) < p_tick);
    shifter_busy = $urandom_range(1);
    tx_wdata = 8'($urandom);
    rx_wdata = 8'($urandom);
    if ($urandom_range(99) < p_ctl) begin
      wm_we = 1; wm_wdata = 16'($urandom);
    end
    if ($urandom_range(99) < p_ctl) begin
      mask_we = 1; mask_wdata = 4'($urandom);
    end
    if ($urandom_range(99) < p_ctl) begin
      clr_we = 1; clr_wdata = 2'($urandom);
    end
    step();
  endtask

  initial begin
    void'($urandom(32'h5fa1_0c3d));
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R8 reset state
    check(status == 5'b00011, "R8 reset status", status, 5'b00011);
    check(raw_irq == 4'b1000, "R8 reset raw", raw_irq, 4'b1000);
    check(irq == 1'b0, "R8 reset irq", irq, 0);
    check(masked_irq == 4'h0, "R8 reset masked", masked_irq, 0);
    @(negedge clk);

    // R3 pops on empty queues
    tx_pop = 1; rx_pop = 1; step();
    // R7 enable all mask bits
    mask_we = 1; mask_wdata = 4'hF; step();

    // balanced random traffic
    for (int i = 0; i < 600; i++) rand_cycle(50, 45, 50, 45, 30, 5);

    // R4 fill receive queue with pops disabled until it overflows
    for (int i = 0; i < 320; i++) rand_cycle(20, 20, 95, 0, 0, 0);
    // R4 clear coinciding with another overflowing push: set wins
    rx_push = 1; rx_wdata = 8'hA5; clr_we = 1; clr_wdata = 2'b01; step();
    check(raw_irq[0] == 1'b1, "R4 set beats clear", raw_irq[0], 1);
    clr_we = 1; clr_wdata = 2'b01; step();
    check(raw_irq[0] == 1'b0, "R4 clear", raw_irq[0], 0);

    // R3 fill transmit queue past full
    for (int i = 0; i < 300; i++) rand_cycle(95, 0, 0, 0, 0, 0);
    check(status[1] == 1'b0, "R3 tx full", status[1], 0);

    // R6 program thresholds: rx 0x7F, tx 0x05
    wm_we = 1; wm_wdata = 16'h7F05; step();
    check(raw_irq[2] == 1'b1 && raw_irq[3] == 1'b0, "R6 fields", raw_irq, 4'b0100);

    // drain both queues
    for (int i = 0; i < 300; i++) rand_cycle(0, 95, 0, 95, 0, 0);

    // R5 directed timeout: one byte, 31 ticks idle, then the 32nd
    clr_we = 1; clr_wdata = 2'b11; rx_push = 1; rx_wdata = 8'h3C; step();
    for (int i = 0; i < TMO - 1; i++) begin
      bit_tick = 1; step();
    end
    check(raw_irq[1] == 1'b0, "R5 before limit", raw_irq[1], 0);
    bit_tick = 1; step();
    check(raw_irq[1] == 1'b1, "R5 at limit", raw_irq[1], 1);
    // R5 clear wins over same-cycle expiry
    bit_tick = 1; clr_we = 1; clr_wdata = 2'b10; step();
    check(raw_irq[1] == 1'b0, "R5 clear wins", raw_irq[1], 0);
    rx_pop = 1; step();

    // tick-heavy random traffic with sparse pops
    for (int i = 0; i < 800; i++) rand_cycle(40, 40, 30, 5, 80, 4);
    for (int i = 0; i < 400; i++) rand_cycle(50, 50, 50, 50, 50, 10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule